// File: doc/BRIEF.md
# UART Receive/Transmit FIFO and Interrupt Identification Logic

This block holds the byte queues and the interrupt logic of a FIFO-buffered serial port. Bytes from a deserialiser arrive on a valid strobe and go into a 16-entry receive queue. The host drains that queue through a small register window. Bytes the host writes go into a 16-entry transmit queue, and the serialiser pulls them out with a pop strobe. The block does not generate baud rates, shift bits, or handle modem lines.

Four interrupt sources are ranked against each other. The highest is a receiver overrun. Next is receive data that has reached a programmable fill threshold. Below that is a character timeout for leftover bytes that sit under the threshold. The lowest is a transmit queue that has gone empty. The winner is reported through an identification code. The top two bits of that code also show whether the queues are enabled. A single interrupt line is high whenever any enabled source is pending.

With the queues disabled, the block acts as a one-byte holding register in each direction, and receive data interrupts as soon as a byte is present.

Top module: `uart_fifo_irq`

## Requirements
- R1: After reset, the identification register reads 0x01, the line status register reads 0x20 and `irq` is low.
- R2: The register window is selected by `reg_addr`:
  - 0 is data. A read returns and removes the oldest received byte. A write queues a transmit byte.
  - 1 is interrupt enable: bit0 receive data and timeout, bit1 transmit empty, bit2 line status. It reads back in bits 2:0.
  - 2 reads identification and writes queue control.
  - 3 is line status: bit0 data ready, bit1 overrun, bit5 transmit queue empty.
- R3: In queue control, bits 7:6 pick the receive threshold: 00 gives 1, 01 gives 4, 10 gives 8, 11 gives 14. Bit3 drives `dma_sel`. Bit1 empties the receive queue and bit2 empties the transmit queue. Changing bit0 (queue enable) empties both queues.
- R4: With queues enabled, each queue holds 16 bytes in arrival order. A byte offered to a full receive queue is discarded.
- R5: With queues disabled, each direction holds one byte. Receive-data interrupt code 0x04 is raised whenever a byte is present.
- R6: With queues enabled, code 0x04 is raised only while the receive count is at or above the threshold.
- R7: A byte arriving while the receive queue is full sets line status bit1. A line status read clears it. While it is set and interrupt enable bit2 is set, the code is 0x06, which outranks every other source.
- R8: With queues enabled, if the receive queue is non-empty and no byte has entered or left it for 4×`char_cycles` clock cycles, code 0x0C is raised. It ranks below 0x06 and 0x04. A data read clears it.
- R9: Code 0x02 (transmit empty) ranks lowest. It is set when the transmit queue empties. It is cleared by a data write, or by an identification read that returned 0x02.
- R10: Identification bits 7:6 read 11 while queues are enabled and 00 otherwise. The code 0x01 means nothing is pending, and `irq` is high exactly when something is pending.
- R11: `tx_avail` and `tx_data` present the oldest transmit byte. `tx_pop` removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (applies read side effects) |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from current state |
| char_cycles | input | CHAR_W | Clock cycles per character time |
| tx_pop | input | 1 | Serialiser takes the oldest transmit byte |
| tx_avail | output | 1 | Transmit byte available |
| tx_data | output | 8 | Oldest transmit byte |
| dma_sel | output | 1 | DMA mode selection from queue control bit3 |
| irq | output | 1 | Interrupt request |

## Verification
The embedded properties are checked on every cycle:
- the queue count stays within its depth;
- a push against a full queue leaves the count unchanged;
- the one-byte limit holds while the queues are disabled;
- overrun is always flagged after a rejected arrival;
- a pending timeout never coexists with an empty queue;
- `irq` always agrees with the low bit of the code.

Only the bench scenarios can show the following:
- the exact threshold crossings for each trigger setting;
- the ordering of codes when several sources are pending at once;
- the length of the timeout window;
- the clearing effects of reads and control writes;
- the byte order seen through the data register.

// File: rtl/uart_fifo_irq_pkg.sv
// Shared constants for the UART queue/interrupt block.
// Assumes an 8-bit register window with four registers.
package uart_fifo_irq_pkg;

    localparam logic [3:0] IID_NONE = 4'h1;
    localparam logic [3:0] IID_LINE = 4'h6;
    localparam logic [3:0] IID_RXD  = 4'h4;
    localparam logic [3:0] IID_TMO  = 4'hC;
    localparam logic [3:0] IID_THRE = 4'h2;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_IEN  = 2'd1,
        REG_IID  = 2'd2,
        REG_LSR  = 2'd3
    } reg_sel_e;

    // Maps the two threshold select bits to a byte count.
    function automatic logic [7:0] trig_level(input logic [1:0] sel);
        case (sel)
            2'b00:   return 8'd1;
            2'b01:   return 8'd4;
            2'b10:   return 8'd8;
            default: return 8'd14;
        endcase
    endfunction

endpackage

// File: rtl/uif_fifo.sv
// Byte queue with a runtime capacity limit (cap <= DEPTH) and a clear.
// A push is refused when count >= cap. Push and pop may share a cycle.
// Clear wins over push and pop. rdata shows the oldest entry.
module uif_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [CW-1:0] cap,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          acc_push, acc_pop;

    assign full     = (count >= cap);
    assign empty    = (count == '0);
    assign acc_push = push && !full;
    assign acc_pop  = pop && !empty;
    assign rdata    = mem[rd_ptr];

    // Next pointer with wrap at DEPTH-1.
    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (acc_push) wr_ptr <= nxt(wr_ptr);
            if (acc_pop)  rd_ptr <= nxt(rd_ptr);
            case ({acc_push, acc_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // Storage write for accepted bytes.
    always_ff @(posedge clk) begin
        if (acc_push && !clr) mem[wr_ptr] <= wdata;
    end

    // R4
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R4
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> (count == $past(count)));

endmodule

// File: rtl/uif_rx_timeout.sv
// Character timeout detector. It counts idle cycles while the receive queue
// holds data and the queues are enabled. Any push, pop or clear restarts
// the count. When the count reaches 4*char_cycles, pending is set. Pending
// is dropped on a pop, a clear, or when the queues are disabled.
// A char_cycles value of zero never fires.
module uif_rx_timeout #(
    parameter int CHW = 16,
    localparam int LW = CHW + 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable,
    input  logic           has_data,
    input  logic           activity,
    input  logic           drain,
    input  logic [CHW-1:0] char_cycles,
    output logic           pending
);
    logic [LW-1:0] cnt;
    logic [LW-1:0] limit;

    assign limit = {char_cycles, 2'b00};

    // Idle counter: restarts on activity, stops at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || activity || !has_data || !enable)
            cnt <= '0;
        else if (cnt != limit)
            cnt <= cnt + LW'(1);
    end

    // Pending flag: set on reaching the limit, dropped on drain.
    always_ff @(posedge clk) begin
        if (!rst_n || drain || !enable)
            pending <= 1'b0;
        else if (has_data && !activity && limit != '0 && cnt == limit)
            pending <= 1'b1;
    end

    // R8
    tmo_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> has_data);

endmodule

// File: rtl/uif_irq_prio.sv
// Interrupt ranking. Pure combinational logic.
// Order: overrun, receive threshold, timeout, transmit empty.
// iid[7:6] show the queue-enable state. irq is derived separately from
// the OR of enabled sources.
module uif_irq_prio #(
    parameter int CW = 5
) (
    input  logic          fifo_en,
    input  logic [2:0]    ien,
    input  logic          ovr,
    input  logic [CW-1:0] rx_count,
    input  logic [7:0]    trig,
    input  logic          tmo,
    input  logic          thre,
    output logic [7:0]    iid,
    output logic          irq
);
    import uart_fifo_irq_pkg::*;

    logic level_ok;
    logic s_line, s_rxd, s_tmo, s_thre;
    logic [3:0] code;

    assign level_ok = fifo_en ? (8'(rx_count) >= trig) : (rx_count != '0);
    assign s_line   = ien[2] && ovr;
    assign s_rxd    = ien[0] && level_ok;
    assign s_tmo    = ien[0] && tmo;
    assign s_thre   = ien[1] && thre;

    // Picks the highest ranked pending source.
    always_comb begin
        if (s_line)      code = IID_LINE;
        else if (s_rxd)  code = IID_RXD;
        else if (s_tmo)  code = IID_TMO;
        else if (s_thre) code = IID_THRE;
        else             code = IID_NONE;
    end

    assign iid = {{2{fifo_en}}, 2'b00, code};
    assign irq = s_line | s_rxd | s_tmo | s_thre;

endmodule

// File: rtl/uart_fifo_irq.sv
// Top of the UART queue/interrupt block. It decodes the register window,
// holds the control and enable state, the overrun and transmit-empty
// flags, and instantiates two queues, the timeout detector and the ranker.
// Assumes the host never strobes reg_wr and reg_rd in the same cycle.
module uart_fifo_irq #(
    parameter int DEPTH  = 16,
    parameter int CHAR_W = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [CHAR_W-1:0] char_cycles,
    input  logic              tx_pop,
    output logic              tx_avail,
    output logic [7:0]        tx_data,
    output logic              dma_sel,
    output logic              irq
);
    import uart_fifo_irq_pkg::*;

    reg_sel_e      sel;
    logic          fifo_en;
    logic [1:0]    trig_sel;
    logic [2:0]    ien;
    logic          ovr_q, thre_q;
    logic          wr_data, rd_data, wr_ctl, rd_iid, rd_lsr;
    logic          en_change, rx_clr, tx_clr;
    logic [CW-1:0] cap;
    logic [7:0]    rx_head;
    logic [CW-1:0] rx_count, tx_count;
    logic          rx_full, rx_empty, tx_full, tx_empty;
    logic          tmo_pend;
    logic [7:0]    iid;
    logic [7:0]    lsr;
    logic          unused_ok;

    assign sel       = reg_sel_e'(reg_addr);
    assign wr_data   = reg_wr && sel == REG_DATA;
    assign rd_data   = reg_rd && sel == REG_DATA;
    assign wr_ctl    = reg_wr && sel == REG_IID;
    assign rd_iid    = reg_rd && sel == REG_IID;
    assign rd_lsr    = reg_rd && sel == REG_LSR;
    assign en_change = wr_ctl && (reg_wdata[0] != fifo_en);
    assign rx_clr    = wr_ctl && (reg_wdata[1] || en_change);
    assign tx_clr    = wr_ctl && (reg_wdata[2] || en_change);
    assign cap       = fifo_en ? CW'(DEPTH) : CW'(1);
    assign unused_ok = ^{reg_wdata[5:4], tx_full};

    // Queue control and interrupt enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_en  <= 1'b0;
            trig_sel <= 2'b00;
            dma_sel  <= 1'b0;
            ien      <= 3'b000;
        end else begin
            if (wr_ctl) begin
                fifo_en  <= reg_wdata[0];
                trig_sel <= reg_wdata[7:6];
                dma_sel  <= reg_wdata[3];
            end
            if (reg_wr && sel == REG_IEN) ien <= reg_wdata[2:0];
        end
    end

    uif_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .cap(cap),
        .push(rx_valid), .wdata(rx_data), .pop(rd_data),
        .rdata(rx_head), .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    uif_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr), .cap(cap),
        .push(wr_data), .wdata(reg_wdata), .pop(tx_pop),
        .rdata(tx_data), .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    assign tx_avail = !tx_empty;

    uif_rx_timeout #(.CHW(CHAR_W)) u_tmo (
        .clk(clk), .rst_n(rst_n), .enable(fifo_en), .has_data(!rx_empty),
        .activity((rx_valid && !rx_full) || rd_data || rx_clr),
        .drain(rd_data || rx_clr),
        .char_cycles(char_cycles), .pending(tmo_pend)
    );

    // Overrun flag: set by a rejected arrival, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ovr_q <= 1'b0;
        else if (rx_valid && rx_full) ovr_q <= 1'b1;
        else if (rd_lsr)             ovr_q <= 1'b0;
    end

    // Transmit-empty flag: set when the queue drains or is cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 thre_q <= 1'b1;
        else if (wr_data)                           thre_q <= 1'b0;
        else if (tx_clr)                            thre_q <= 1'b1;
        else if (tx_pop && tx_count == CW'(1))      thre_q <= 1'b1;
        else if (rd_iid && iid[3:0] == IID_THRE)    thre_q <= 1'b0;
    end

    uif_irq_prio #(.CW(CW)) u_prio (
        .fifo_en(fifo_en), .ien(ien), .ovr(ovr_q), .rx_count(rx_count),
        .trig(trig_level(trig_sel)), .tmo(tmo_pend), .thre(thre_q),
        .iid(iid), .irq(irq)
    );

    assign lsr = {2'b00, tx_empty, 3'b000, ovr_q, !rx_empty};

    // Read data mux, taken from the current state.
    always_comb begin
        case (sel)
            REG_DATA: reg_rdata = rx_empty ? 8'h00 : rx_head;
            REG_IEN:  reg_rdata = {5'b00000, ien};
            REG_IID:  reg_rdata = iid;
            default:  reg_rdata = lsr;
        endcase
    end

    // R7
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_full) |=> lsr[1]);

    // R5
    legacy_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> (rx_count <= CW'(1) && tx_count <= CW'(1)));

    // R10
    irq_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == !iid[0]);

    // R10
    iid_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iid[7:6] == {2{fifo_en}});

endmodule

// File: tb/uart_fifo_irq_tb.sv
// Scoreboard bench. Driver tasks queue expected receive bytes. A monitor
// pops and compares them whenever the data register is read.
module uart_fifo_irq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic [15:0] char_cycles = 16'd5;
    logic        tx_pop = 1'b0;
    logic        tx_avail;
    logic [7:0]  tx_data;
    logic        dma_sel;
    logic        irq;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_q [$];

    always #10 clk = ~clk;

    uart_fifo_irq u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .char_cycles(char_cycles), .tx_pop(tx_pop), .tx_avail(tx_avail),
        .tx_data(tx_data), .dma_sel(dma_sel), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, got, exp);
        end
    endtask

    // Monitor: compares every data register read against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && reg_rd && reg_addr == 2'd0) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R4 unexpected read actual=%02h expected=none", reg_rdata);
            end else begin
                check("R4 order", reg_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic push_rx(input logic [7:0] b, input bit keep);
        rx_valid = 1'b1; rx_data = b;
        if (keep) exp_q.push_back(b);
        @(posedge clk); #2;
        rx_valid = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #2;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk); #2;
        reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pop_tx();
        tx_pop = 1'b1;
        @(posedge clk); #2;
        tx_pop = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        peek(2'd2, v); check("R1 iid", v, 8'h01);
        peek(2'd3, v); check("R1 lsr", v, 8'h20);
        check("R1 irq", {7'd0, irq}, 8'h00);

        // R2 enable register readback
        wr(2'd1, 8'h05);
        peek(2'd1, v); check("R2 ien", v, 8'h05);

        // R5 queues disabled: one-byte holding, data interrupt immediately
        push_rx(8'hA1, 1);
        peek(2'd2, v); check("R5 iid", v, 8'h04);
        check("R5 irq", {7'd0, irq}, 8'h01);
        peek(2'd3, v); check("R2 lsr dr", v, 8'h21);
        push_rx(8'hB2, 0);
        // R7 overrun ranks first
        peek(2'd2, v); check("R7 iid", v, 8'h06);
        rd(2'd3, v); check("R7 lsr", v, 8'h23);
        peek(2'd2, v); check("R7 cleared", v, 8'h04);
        rd(2'd0, v);
        peek(2'd2, v); check("R10 none", v, 8'h01);
        check("R10 irq low", {7'd0, irq}, 8'h00);

        // R6 threshold 4
        wr(2'd2, 8'h41);
        peek(2'd2, v); check("R10 hi bits", v, 8'hC1);
        push_rx(8'h10, 1); push_rx(8'h11, 1); push_rx(8'h12, 1);
        peek(2'd2, v); check("R6 below", v, 8'hC1);
        push_rx(8'h13, 1);
        peek(2'd2, v); check("R6 at level", v, 8'hC4);
        repeat (4) rd(2'd0, v);

        // R8 timeout: char_cycles=5 gives 20 idle cycles
        push_rx(8'h20, 1); push_rx(8'h21, 1);
        idle(10);
        peek(2'd2, v); check("R8 early", v, 8'hC1);
        idle(20);
        peek(2'd2, v); check("R8 fired", v, 8'hCC);
        rd(2'd0, v);
        peek(2'd2, v); check("R8 cleared", v, 8'hC1);
        idle(25);
        peek(2'd2, v); check("R8 again", v, 8'hCC);
        rd(2'd0, v);
        peek(2'd3, v); check("R8 empty lsr", v, 8'h20);

        // R3 threshold 14, R4 depth 16 and drop when full
        wr(2'd2, 8'hC1);
        for (int i = 0; i < 13; i++) push_rx(8'h40 + 8'(i), 1);
        peek(2'd2, v); check("R3 thr14 below", v, 8'hC1);
        push_rx(8'h4D, 1);
        peek(2'd2, v); check("R3 thr14 at", v, 8'hC4);
        push_rx(8'h4E, 1); push_rx(8'h4F, 1);
        push_rx(8'hEE, 0);
        peek(2'd2, v); check("R7 full overrun", v, 8'hC6);
        rd(2'd3, v); check("R4 lsr full", v, 8'h23);
        peek(2'd2, v); check("R7 after read", v, 8'hC4);
        repeat (16) rd(2'd0, v);

        // R3 receive clear bit
        push_rx(8'h77, 0); push_rx(8'h78, 0);
        wr(2'd2, 8'hC3);
        peek(2'd3, v); check("R3 rx clear", v, 8'h20);

        // R3 threshold 1
        wr(2'd2, 8'h01);
        push_rx(8'h5A, 1);
        peek(2'd2, v); check("R3 thr1", v, 8'hC4);
        rd(2'd0, v);

        // R9 transmit empty, R11 transmit path
        wr(2'd1, 8'h07);
        rd(2'd2, v); check("R9 thre", v, 8'hC2);
        peek(2'd2, v); check("R9 read clears", v, 8'hC1);
        wr(2'd0, 8'h11); wr(2'd0, 8'h22);
        check("R11 avail", {7'd0, tx_avail}, 8'h01);
        check("R11 head", tx_data, 8'h11);
        peek(2'd3, v); check("R11 lsr busy", v, 8'h00);
        pop_tx();
        check("R11 second", tx_data, 8'h22);
        pop_tx();
        check("R11 drained", {7'd0, tx_avail}, 8'h00);
        peek(2'd2, v); check("R9 set on drain", v, 8'hC2);
        push_rx(8'h66, 1);
        peek(2'd2, v); check("R9 ranks below rx", v, 8'hC4);
        rd(2'd0, v);
        peek(2'd2, v); check("R9 back", v, 8'hC2);

        // R3 DMA select bit
        wr(2'd2, 8'h09);
        check("R3 dma", {7'd0, dma_sel}, 8'h01);
        peek(2'd2, v); check("R3 no clear", v, 8'hC2);

        // R10 queues disabled: high bits clear
        wr(2'd2, 8'h00);
        peek(2'd2, v); check("R10 disabled", v, 8'h02);
        check("R10 irq", {7'd0, irq}, 8'h01);

        idle(2);
        finish_run();
    end
endmodule